// File: doc/BRIEF.md
# Dual-Source Divider Setting Register

This block holds the two settings of a clock synthesizer's divider chain: a 6-bit feedback multiplier value `M` and a 2-bit output divider code `N`. The output frequency is the reference times `M`, divided by the ratio that `N` selects. For example, a 19.44 MHz reference with `M` = 32 gives 622.08 MHz at ratio 1 and 311.04 MHz at ratio 2. The settings can come from two sources, and both feed the same held outputs.

The first source is a parallel one. While an active-low strobe is low, the block copies hardwired or driven pins to the settings. When the strobe rises, the settings freeze. The second source is a three-wire serial port with data, clock and load lines. A 14-bit frame is shifted in, first bit first. A rising load moves the frame's fields into the settings, and a falling load freezes them. While load stays high, every serial clock updates the settings directly.

All strobe, clock and data pins are brought into the block clock domain through synchronizers. Edge detection then runs in that domain. Besides the two settings, the block drives a decoded ratio output.

Top module: `divcfg_reg`

## Requirements
- R1: An active-high reset loads `mSetting` with DEF_M (default 32) and `nSetting` with DEF_N (default 0), and clears the shift register. A serial load with no bits shifted after reset then gives `M` = 0 and `N` = 0.
- R2: While `parLoadN` is low, `mSetting` and `nSetting` follow `parM` and `parN`. An output reflects an input change within SYNC_STAGES+1 clock cycles.
- R3: After `parLoadN` rises, the settings keep the last parallel values, and later changes on `parM` or `parN` have no effect.
- R4: While `parLoadN` is high and `serLoad` is low, each rising `serClk` shifts `serData` into a 14-bit shift register, and the settings do not change.
- R5: A rising `serLoad` (with `parLoadN` high) copies fields of the shift register into the settings. In a frame sent first bit first, bits 4 and 5 are N1 and N0, and bits 9 to 14 are M5 down to M0.
- R6: After `serLoad` falls, the settings hold, and further shifting does not change them.
- R7: While `serLoad` is high and `parLoadN` is high, each rising `serClk` shifts in one bit. The settings then take the fields of the updated shift register at once.
- R8: Frame bits 1 to 3 and 6 to 8 (padding and null positions) have no effect on the loaded settings, whatever their value.
- R9: While `parLoadN` is low, serial clocks and loads change neither the settings nor the shift register contents.
- R10: `divRatio` is 1, 2, 4 or 8 for `nSetting` codes 00, 01, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample all control pins |
| rst | input | 1 | Active-high master reset |
| parLoadN | input | 1 | Active-low parallel strobe: low = transparent, rise = freeze |
| parM | input | 6 | Parallel multiplier value |
| parN | input | 2 | Parallel output divider code |
| serClk | input | 1 | Serial shift clock, sampled for rising edges |
| serData | input | 1 | Serial data bit |
| serLoad | input | 1 | Serial load: rise = transfer, high = pass-through, fall = hold |
| mSetting | output | 6 | Held multiplier setting |
| nSetting | output | 2 | Held output divider code |
| divRatio | output | 4 | Decoded output divide ratio (1, 2, 4 or 8) |

## Verification
The bench uses the default parameters: two synchronizer stages, a 6-bit `M`, a 2-bit `N`, a 14-bit frame with padding in front, and a reset default of `M` = 32. With these values, a settling window of six block cycles covers every path. The bench can then sweep all four ratio codes and both extreme `M` values through the parallel path. It also sends frames with the padding and null positions set to ones, so a misplaced field tap shows up at the outputs. The bench keeps its own model of the shift register, so the pass-through mode and the parallel-low lockout are checked against the exact 14-bit frame positions.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  // Per-cycle actions issued by the control to the datapath
  typedef struct packed {
    logic loadPar;     // copy parallel pins into the settings
    logic loadSerial;  // copy shift register fields into the settings
    logic passSerial;  // shift and copy the shifted fields in the same cycle
    logic shiftEn;     // shift one serial bit in
  } cfgStrobe_t;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/divcfg_ctrl.sv
module divcfg_ctrl
  import divcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       parLoadNS,
  input  logic       serLoadS,
  input  logic       serClkS,
  output cfgStrobe_t strobes
);
  logic serClkPrev;
  logic serLoadPrev;
  logic clkRise;
  logic loadRise;

  always_ff @(posedge clk) begin
    if (rst) begin
      serClkPrev  <= 1'b0;
      serLoadPrev <= 1'b0;
    end else begin
      serClkPrev  <= serClkS;
      serLoadPrev <= serLoadS;
    end
  end

  assign clkRise  = serClkS & ~serClkPrev;
  assign loadRise = serLoadS & ~serLoadPrev;

  always_comb begin
    strobes = '0;
    if (!parLoadNS) begin
      // parallel path wins whenever its strobe is low
      strobes.loadPar = 1'b1;
    end else begin
      strobes.shiftEn    = clkRise;
      strobes.passSerial = clkRise & serLoadS;
      strobes.loadSerial = loadRise & ~clkRise;
    end
  end

  // R9: no serial action while the parallel strobe is low
  assert_par_lockout_R9: assert property (@(posedge clk) disable iff (rst)
    !parLoadNS |-> !(strobes.shiftEn || strobes.loadSerial || strobes.passSerial));

  // R5/R7: at most one setting source per cycle
  assert_one_source_R5: assert property (@(posedge clk) disable iff (rst)
    $countones({strobes.loadPar, strobes.loadSerial, strobes.passSerial}) <= 1);

  // R4: shifting only on a sampled rising serial clock
  assert_shift_edge_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |-> (serClkS && !serClkPrev));
endmodule

// File: rtl/divcfg_datapath.sv
module divcfg_datapath
  import divcfg_pkg::*;
#(
  parameter int M_WIDTH = 6,
  parameter int N_WIDTH = 2,
  parameter int PAD_BITS = 2,
  parameter int NULL_LEAD = 1,
  parameter int NULL_MID = 3,
  parameter logic [M_WIDTH-1:0] DEF_M = 6'd32,
  parameter logic [N_WIDTH-1:0] DEF_N = 2'd0,
  localparam int FRAME_LEN = PAD_BITS + NULL_LEAD + N_WIDTH + NULL_MID + M_WIDTH,
  localparam int N_LSB = M_WIDTH + NULL_MID,
  localparam int RATIO_W = 1 << N_WIDTH
) (
  input  logic               clk,
  input  logic               rst,
  input  cfgStrobe_t         strobes,
  input  logic [M_WIDTH-1:0] parM,
  input  logic [N_WIDTH-1:0] parN,
  input  logic               serBit,
  output logic [M_WIDTH-1:0] mSetting,
  output logic [N_WIDTH-1:0] nSetting,
  output logic [RATIO_W-1:0] divRatio
);
  logic [FRAME_LEN-1:0] shiftReg;
  logic [FRAME_LEN-1:0] shiftNext;
  logic [M_WIDTH-1:0]   mReg;
  logic [N_WIDTH-1:0]   nReg;

  assign shiftNext = {shiftReg[FRAME_LEN-2:0], serBit};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= shiftNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mReg <= DEF_M;
      nReg <= DEF_N;
    end else if (strobes.loadPar) begin
      mReg <= parM;
      nReg <= parN;
    end else if (strobes.passSerial) begin
      mReg <= shiftNext[M_WIDTH-1:0];
      nReg <= shiftNext[N_LSB +: N_WIDTH];
    end else if (strobes.loadSerial) begin
      mReg <= shiftReg[M_WIDTH-1:0];
      nReg <= shiftReg[N_LSB +: N_WIDTH];
    end
  end

  // ratio decode: one bit per code value
  always_comb begin
    for (int i = 0; i < RATIO_W; i++) divRatio[i] = (nReg == N_WIDTH'(i));
  end

  assign mSetting = mReg;
  assign nSetting = nReg;

  // R2: transparent parallel path
  assert_par_follow_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.loadPar |=> (mSetting == $past(parM)) && (nSetting == $past(parN)));

  // R6: settings hold when no source is active
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(strobes.loadPar || strobes.loadSerial || strobes.passSerial)
      |=> $stable(mSetting) && $stable(nSetting));

  // R9: shift register untouched without a shift strobe
  assert_sr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strobes.shiftEn |=> $stable(shiftReg));

  // R10: exactly one ratio selected
  assert_ratio_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(divRatio) == 1);
endmodule

// File: rtl/divcfg_reg.sv
module divcfg_reg
  import divcfg_pkg::*;
#(
  parameter int M_WIDTH = 6,
  parameter int N_WIDTH = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PAD_BITS = 2,
  parameter int NULL_LEAD = 1,
  parameter int NULL_MID = 3,
  parameter logic [M_WIDTH-1:0] DEF_M = 6'd32,
  parameter logic [N_WIDTH-1:0] DEF_N = 2'd0,
  localparam int RATIO_W = 1 << N_WIDTH,
  localparam int PIN_W = M_WIDTH + N_WIDTH + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               parLoadN,
  input  logic [M_WIDTH-1:0] parM,
  input  logic [N_WIDTH-1:0] parN,
  input  logic               serClk,
  input  logic               serData,
  input  logic               serLoad,
  output logic [M_WIDTH-1:0] mSetting,
  output logic [N_WIDTH-1:0] nSetting,
  output logic [RATIO_W-1:0] divRatio
);
  logic [PIN_W-1:0]   dataS;
  logic [2:0]         ctlS;
  logic [M_WIDTH-1:0] parMS;
  logic [N_WIDTH-1:0] parNS;
  logic               serDataS;
  cfgStrobe_t         strobes;

  // data pins share the control pins' latency so edges and data stay aligned
  divcfg_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) uDataSync (
    .clk(clk), .rst(rst), .din({parM, parN, serData}), .dout(dataS)
  );

  divcfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uCtlSync (
    .clk(clk), .rst(rst), .din({parLoadN, serLoad, serClk}), .dout(ctlS)
  );

  assign {parMS, parNS, serDataS} = dataS;

  divcfg_ctrl uCtrl (
    .clk(clk), .rst(rst),
    .parLoadNS(ctlS[2]), .serLoadS(ctlS[1]), .serClkS(ctlS[0]),
    .strobes(strobes)
  );

  divcfg_datapath #(
    .M_WIDTH(M_WIDTH), .N_WIDTH(N_WIDTH), .PAD_BITS(PAD_BITS),
    .NULL_LEAD(NULL_LEAD), .NULL_MID(NULL_MID), .DEF_M(DEF_M), .DEF_N(DEF_N)
  ) uDp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .parM(parMS), .parN(parNS), .serBit(serDataS),
    .mSetting(mSetting), .nSetting(nSetting), .divRatio(divRatio)
  );
endmodule

// File: tb/divcfg_reg_test.sv
module divcfg_reg_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic parLoadN = 1'b1;
  logic [5:0] parM = '0;
  logic [1:0] parN = '0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serLoad = 1'b0;
  logic [5:0] mSetting;
  logic [1:0] nSetting;
  logic [3:0] divRatio;

  int checks = 0;
  int failures = 0;
  logic [13:0] tbSr = '0;

  always #4 clk = ~clk;

  divcfg_reg uut (
    .clk(clk), .rst(rst), .parLoadN(parLoadN), .parM(parM), .parN(parN),
    .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .mSetting(mSetting), .nSetting(nSetting), .divRatio(divRatio)
  );

  // {M, N, expected ratio}
  localparam logic [11:0] VEC [8] = '{
    {6'd32, 2'd0, 4'd1}, {6'd32, 2'd1, 4'd2}, {6'd0,  2'd2, 4'd4},
    {6'd63, 2'd3, 4'd8}, {6'd3,  2'd0, 4'd1}, {6'd42, 2'd1, 4'd2},
    {6'd21, 2'd2, 4'd4}, {6'd1,  2'd3, 4'd8}
  };

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkAll(string req, int m, int n, int r);
    chk(req, int'(mSetting), m);
    chk(req, int'(nSetting), n);
    chk(req, int'(divRatio), r);
  endtask

  task automatic sendBit(logic b);
    serData = b;
    cyc(3);
    serClk = 1'b1;
    cyc(4);
    serClk = 1'b0;
    cyc(4);
    if (parLoadN) tbSr = {tbSr[12:0], b};
  endtask

  // first bit first: 3 fill, N1, N0, 3 fill, M5..M0
  task automatic sendFrame(logic [5:0] m, logic [1:0] n, logic fill);
    for (int i = 0; i < 3; i++) sendBit(fill);
    sendBit(n[1]);
    sendBit(n[0]);
    for (int i = 0; i < 3; i++) sendBit(fill);
    for (int i = 5; i >= 0; i--) sendBit(m[i]);
  endtask

  task automatic pulseLoad();
    serLoad = 1'b1;
    cyc(6);
    serLoad = 1'b0;
    cyc(6);
  endtask

  function automatic int ratioOf(logic [1:0] n);
    return 1 << n;
  endfunction

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(6);
    chkAll("R1 default", 32, 0, 1);
    pulseLoad();
    chkAll("R1 cleared shift register", 0, 0, 1);

    // R2 / R10: parallel table sweep
    parLoadN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      parM = VEC[i][11:6];
      parN = VEC[i][5:4];
      cyc(6);
      chkAll("R2 R10 parallel vector", int'(VEC[i][11:6]), int'(VEC[i][5:4]), int'(VEC[i][3:0]));
    end

    // R3: latch on strobe rise
    parM = 6'd45; parN = 2'd2;
    cyc(6);
    parLoadN = 1'b1;
    cyc(6);
    parM = 6'd7; parN = 2'd3;
    cyc(6);
    chkAll("R3 latched", 45, 2, 4);

    // R4: shifting leaves settings alone
    sendFrame(6'd20, 2'd3, 1'b0);
    chkAll("R4 shift only", 45, 2, 4);

    // R5: transfer on load rise, R6 hold after fall
    serLoad = 1'b1;
    cyc(6);
    chkAll("R5 transfer", 20, 3, 8);
    serLoad = 1'b0;
    cyc(6);
    sendFrame(6'd9, 2'd1, 1'b0);
    chkAll("R6 hold", 20, 3, 8);
    pulseLoad();
    chkAll("R5 second frame", 9, 1, 2);

    // R8: fill bits set to one are ignored
    sendFrame(6'd50, 2'd2, 1'b1);
    pulseLoad();
    chkAll("R8 fill ignored", 50, 2, 4);

    // R7: pass-through while load high
    serLoad = 1'b1;
    cyc(6);
    sendBit(1'b1);
    chkAll("R7 pass bit1", int'(tbSr[5:0]), int'(tbSr[10:9]), ratioOf(tbSr[10:9]));
    sendBit(1'b0);
    chkAll("R7 pass bit2", int'(tbSr[5:0]), int'(tbSr[10:9]), ratioOf(tbSr[10:9]));
    sendBit(1'b1);
    chkAll("R7 pass bit3", int'(tbSr[5:0]), int'(tbSr[10:9]), ratioOf(tbSr[10:9]));
    serLoad = 1'b0;
    cyc(6);

    // R9: parallel low locks out serial
    parM = 6'd11; parN = 2'd1;
    parLoadN = 1'b0;
    cyc(6);
    chkAll("R9 parallel applied", 11, 1, 2);
    sendFrame(6'd60, 2'd3, 1'b0);
    pulseLoad();
    chkAll("R9 serial ignored", 11, 1, 2);
    parLoadN = 1'b1;
    cyc(6);
    pulseLoad();
    chkAll("R9 shift register untouched", int'(tbSr[5:0]), int'(tbSr[10:9]), ratioOf(tbSr[10:9]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule